// File: doc/BRIEF.md
# Cascaded Interrupt Controller Setup Sequencer

This block is the register front end for two interrupt controllers of the 8259 kind, wired as a primary and a secondary in cascade. It watches a single I/O write port. Each controller answers to two addresses: a command address and the data address directly above it. When a controller's command address receives a byte with bit 4 set, that byte begins the controller's setup. The next three bytes written to its data address complete the setup. Once setup is complete, later writes go to the run-time command and mask words. The block stores every word, applies the fixed settings that cascade operation requires, and reports each controller's progress through setup.

A test readback port picks one controller and one stored word and returns it combinationally. The block contains no request handling, no priority logic and no acknowledge cycle. It only decodes the writes and steps the setup sequence.

Top module: `pic_init_seq`

## Requirements
- R1: After synchronous reset, each controller has phase 0 (idle), its `init_done` bit is 0 and its `rule_err` bit is 0. The readback port returns 19h for word 0 and 00h for words 1 to 6 of both controllers.
- R2: A write to a controller's command address (20h for controller 0, A0h for controller 1) with data bit 4 set is a setup start. On the next cycle that controller's phase is 1 and `init_done` is 0. Its stored word 0 reads 19h whatever the data: bits 7:5 and bits 2:1 are 0, and bits 4, 3 and 0 are 1.
- R3: In phases 1, 2 and 3, a write to the data address (command address + 1) loads word 1, word 2 and word 3 respectively. It moves the phase to 2, 3 and then 0. The third of these writes sets `init_done`.
- R4: `rule_err` for a controller is 1 for exactly the one cycle after a setup start whose data has bit 1 = 1 or bit 0 = 0. It is 0 after any other write.
- R5: A setup start received in phase 1, 2 or 3 returns the phase to 1. Words already loaded keep their values until they are written again.
- R6: With `init_done` = 1, a command-address write with bit 4 = 0 loads word 5 when data bit 3 = 0, or word 6 when bit 3 = 1. Phase and `init_done` stay as they were.
- R7: With `init_done` = 1 and phase 0, a data-address write loads word 4 (the mask).
- R8: A command-address write with bit 4 = 0 while `init_done` = 0 is ignored. So is a data-address write in phase 0 while `init_done` = 0. With no write, phase and `init_done` hold.
- R9: Writes to any address other than the four decoded ones change nothing. A write to one controller never changes the other controller's words, phase, `init_done` or `rule_err`.
- R10: Readback word select codes are 0 to 6 for word 0 (setup start word), words 1 to 3 (setup words), word 4 (mask), word 5 and word 6. Code 7 returns 00h. `rd_ctrl` 0 selects controller 0 and 1 selects controller 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_addr | input | 8 | I/O write address |
| wr_data | input | 8 | I/O write data |
| rd_ctrl | input | 1 | Readback controller select |
| rd_sel | input | 3 | Readback word select |
| rd_data | output | 8 | Readback word |
| phase | output | 4 | Setup phase; bits 1:0 controller 0, bits 3:2 controller 1 |
| init_done | output | 2 | Setup complete, one bit per controller |
| rule_err | output | 2 | Illegal setup start seen, one-cycle flag per controller |

## Verification
The assertions check, on every cycle, the phase rules: a start leads to phase 1, phase 1 steps to phase 2, `init_done` rises only out of phase 3, and state holds when nothing is written. They also check that every `rule_err` pulse traces back to a setup start on its own controller, and that run-time command writes leave a finished controller's phase alone. Stored word contents can only be shown by the bench's scenarios, which read them back. The same goes for the forced bits of word 0, the mask and command routing, the ignored writes, and the independence of the two controllers.

// File: rtl/pic_seq_pkg.sv
package pic_seq_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_CTRL = 2;
    localparam int SEL_W    = 3;

    // Word 0 as stored after any setup start: cascade, setup word 3 required,
    // level bit reads 1, start marker bit 4 set, reserved bits cleared.
    localparam logic [DATA_W-1:0] START_WORD_FIXED = 8'h19;

    localparam int START_MARK_BIT = 4;
    localparam int CMD_PICK_BIT   = 3;
    localparam int SINGLE_BIT     = 1;
    localparam int NEED_W3_BIT    = 0;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_W1   = 2'd1,
        PH_W2   = 2'd2,
        PH_W3   = 2'd3
    } phase_e;

    typedef enum logic [SEL_W-1:0] {
        SEL_START = 3'd0,
        SEL_W1    = 3'd1,
        SEL_W2    = 3'd2,
        SEL_W3    = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_CMDA  = 3'd5,
        SEL_CMDB  = 3'd6,
        SEL_NONE  = 3'd7
    } word_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] start_w;
        logic [DATA_W-1:0] set_w1;
        logic [DATA_W-1:0] set_w2;
        logic [DATA_W-1:0] set_w3;
        logic [DATA_W-1:0] mask_w;
        logic [DATA_W-1:0] cmd_a;
        logic [DATA_W-1:0] cmd_b;
    } word_bank_t;

    typedef struct packed {
        logic hit_cmd;
        logic hit_dat;
    } port_hit_t;

    localparam word_bank_t BANK_RESET = '{
        start_w: START_WORD_FIXED,
        set_w1:  '0,
        set_w2:  '0,
        set_w3:  '0,
        mask_w:  '0,
        cmd_a:   '0,
        cmd_b:   '0
    };

    function automatic logic breaks_rule(input logic [DATA_W-1:0] d);
        return d[SINGLE_BIT] | ~d[NEED_W3_BIT];
    endfunction

    function automatic logic [DATA_W-1:0] pick_word(input word_bank_t b,
                                                    input logic [SEL_W-1:0] s);
        logic [DATA_W-1:0] r;
        case (word_sel_e'(s))
            SEL_START: r = b.start_w;
            SEL_W1:    r = b.set_w1;
            SEL_W2:    r = b.set_w2;
            SEL_W3:    r = b.set_w3;
            SEL_MASK:  r = b.mask_w;
            SEL_CMDA:  r = b.cmd_a;
            SEL_CMDB:  r = b.cmd_b;
            default:   r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pic_port_decode.sv
module pic_port_decode
    import pic_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [NUM_CTRL*ADDR_W-1:0] BASES = {8'hA0, 8'h20}
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output port_hit_t         hits [NUM_CTRL]
);
    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
        localparam logic [ADDR_W-1:0] CMD_A = BASES[c*ADDR_W +: ADDR_W];
        localparam logic [ADDR_W-1:0] DAT_A = CMD_A + ADDR_W'(1);
        always_comb begin
            hits[c].hit_cmd = wr_en && (wr_addr == CMD_A);
            hits[c].hit_dat = wr_en && (wr_addr == DAT_A);
        end
    end
endmodule

// File: rtl/pic_ctrl_seq.sv
module pic_ctrl_seq
    import pic_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  port_hit_t         hit,
    input  logic [DATA_W-1:0] wr_data,
    output phase_e            phase,
    output logic              done,
    output logic              err,
    output word_bank_t        bank
);
    logic is_start;
    assign is_start = hit.hit_cmd && wr_data[START_MARK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
            err   <= 1'b0;
            bank  <= BANK_RESET;
        end else begin
            err <= 1'b0;
            if (is_start) begin
                bank.start_w <= START_WORD_FIXED;
                phase        <= PH_W1;
                done         <= 1'b0;
                err          <= breaks_rule(wr_data);
            end else if (hit.hit_cmd) begin
                if (done) begin
                    if (wr_data[CMD_PICK_BIT]) bank.cmd_b <= wr_data;
                    else                       bank.cmd_a <= wr_data;
                end
            end else if (hit.hit_dat) begin
                case (phase)
                    PH_W1: begin
                        bank.set_w1 <= wr_data;
                        phase       <= PH_W2;
                    end
                    PH_W2: begin
                        bank.set_w2 <= wr_data;
                        phase       <= PH_W3;
                    end
                    PH_W3: begin
                        bank.set_w3 <= wr_data;
                        phase       <= PH_IDLE;
                        done        <= 1'b1;
                    end
                    default: begin
                        if (done) bank.mask_w <= wr_data;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/pic_word_mux.sv
module pic_word_mux
    import pic_seq_pkg::*;
#(
    parameter int CSEL_W = 1
) (
    input  word_bank_t        banks [NUM_CTRL],
    input  logic [CSEL_W-1:0] rd_ctrl,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CTRL; c++) begin
            if (rd_ctrl == CSEL_W'(c)) rd_data = pick_word(banks[c], rd_sel);
        end
    end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE0 = 8'h20,
    parameter logic [ADDR_W-1:0] BASE1 = 8'hA0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_ctrl,
    input  logic [2:0]        rd_sel,
    output logic [7:0]        rd_data,
    output logic [3:0]        phase,
    output logic [1:0]        init_done,
    output logic [1:0]        rule_err
);
    localparam int CSEL_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;

    port_hit_t  hits  [NUM_CTRL];
    word_bank_t banks [NUM_CTRL];
    phase_e     ph    [NUM_CTRL];

    pic_port_decode #(
        .ADDR_W (ADDR_W),
        .BASES  ({BASE1, BASE0})
    ) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .hits    (hits)
    );

    for (genvar c = 0; c < NUM_CTRL; c++) begin : g_seq
        pic_ctrl_seq u_seq (
            .clk     (clk),
            .rst     (rst),
            .hit     (hits[c]),
            .wr_data (wr_data),
            .phase   (ph[c]),
            .done    (init_done[c]),
            .err     (rule_err[c]),
            .bank    (banks[c])
        );
        assign phase[2*c +: 2] = ph[c];
    end

    pic_word_mux #(
        .CSEL_W (CSEL_W)
    ) u_mux (
        .banks   (banks),
        .rd_ctrl (CSEL_W'(rd_ctrl)),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/pic_seq_checker.sv
module pic_seq_checker #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE0 = 8'h20,
    parameter logic [ADDR_W-1:0] BASE1 = 8'hA0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [3:0]        phase,
    input logic [1:0]        init_done,
    input logic [1:0]        rule_err
);
    localparam logic [ADDR_W-1:0] DAT0 = BASE0 + ADDR_W'(1);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (phase == 4'd0 && init_done == 2'b00 && rule_err == 2'b00));

    p_start_enters_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == BASE0 && wr_data[4]) |=> (phase[1:0] == 2'd1 && !init_done[0]));

    p_start_c1_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == BASE1 && wr_data[4]) |=> (phase[3:2] == 2'd1 && !init_done[1]));

    p_first_step_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == DAT0 && phase[1:0] == 2'd1) |=> (phase[1:0] == 2'd2));

    p_done_from_last_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done[0]) |-> $past(phase[1:0] == 2'd3));

    p_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
        rule_err[0] |-> $past(wr_en && wr_addr == BASE0 && wr_data[4]));

    p_err_cause_c1_r4: assert property (@(posedge clk) disable iff (rst)
        rule_err[1] |-> $past(wr_en && wr_addr == BASE1 && wr_data[4]));

    p_cmd_keeps_phase_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == BASE0 && !wr_data[4] && init_done[0] && phase[1:0] == 2'd0)
        |=> (phase[1:0] == 2'd0 && init_done[0]));

    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(phase) && $stable(init_done)));
endmodule

bind pic_init_seq pic_seq_checker #(
    .ADDR_W (ADDR_W),
    .BASE0  (BASE0),
    .BASE1  (BASE1)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .phase     (phase),
    .init_done (init_done),
    .rule_err  (rule_err)
);

// File: tb/tb_pic_init_seq.sv
module tb_pic_init_seq;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_addr;
    logic [7:0] wr_data;
    logic       rd_ctrl;
    logic [2:0] rd_sel;
    logic [7:0] rd_data;
    logic [3:0] phase;
    logic [1:0] init_done;
    logic [1:0] rule_err;

    int n_chk = 0;
    int n_bad = 0;

    pic_init_seq dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_ctrl   (rd_ctrl),
        .rd_sel    (rd_sel),
        .rd_data   (rd_data),
        .phase     (phase),
        .init_done (init_done),
        .rule_err  (rule_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic c, input logic [2:0] s,
                          input logic [7:0] exp);
        rd_ctrl = c;
        rd_sel  = s;
        #1;
        check(tag, rd_data, exp);
    endtask

    task automatic t_reset;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_ctrl = 0; rd_sel = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 phase", {4'h0, phase}, 8'h00);
        check("R1 done", {6'h0, init_done}, 8'h00);
        check("R1 err", {6'h0, rule_err}, 8'h00);
        rd_chk("R1 c0 word0", 0, 3'd0, 8'h19);
        rd_chk("R1 c1 word0", 1, 3'd0, 8'h19);
        for (int s = 1; s < 7; s++) rd_chk("R1 c1 words", 1, 3'(s), 8'h00);
        rd_chk("R10 code7", 0, 3'd7, 8'h00);
    endtask

    task automatic t_ignored_before_init;
        wr(8'hA1, 8'h55);
        rd_chk("R8 mask before init", 1, 3'd4, 8'h00);
        wr(8'hA0, 8'h00);
        rd_chk("R8 cmd before init", 1, 3'd5, 8'h00);
        check("R8 phase held", {4'h0, phase}, 8'h00);
        wr(8'h22, 8'h11);
        wr(8'h1F, 8'h11);
        check("R9 foreign addr", {4'h0, phase}, 8'h00);
    endtask

    task automatic t_full_init_c0;
        wr(8'h20, 8'h11);
        check("R2 phase1", {6'h0, phase[1:0]}, 8'h01);
        check("R4 no err", {6'h0, rule_err}, 8'h00);
        check("R9 c1 untouched", {6'h0, phase[3:2]}, 8'h00);
        rd_chk("R2 word0", 0, 3'd0, 8'h19);
        wr(8'h21, 8'h08);
        check("R3 phase2", {6'h0, phase[1:0]}, 8'h02);
        wr(8'h21, 8'h04);
        check("R3 phase3", {6'h0, phase[1:0]}, 8'h03);
        check("R3 not done", {7'h0, init_done[0]}, 8'h00);
        wr(8'h21, 8'h01);
        check("R3 phase0", {6'h0, phase[1:0]}, 8'h00);
        check("R3 done", {7'h0, init_done[0]}, 8'h01);
        rd_chk("R3 word1", 0, 3'd1, 8'h08);
        rd_chk("R3 word2", 0, 3'd2, 8'h04);
        rd_chk("R3 word3", 0, 3'd3, 8'h01);
        rd_chk("R9 c1 word1", 1, 3'd1, 8'h00);
    endtask

    task automatic t_rule_err;
        wr(8'hA0, 8'h12);
        check("R4 err c1 single", {6'h0, rule_err}, 8'h02);
        @(negedge clk);
        check("R4 err one cycle", {6'h0, rule_err}, 8'h00);
        rd_chk("R2 forced word0", 1, 3'd0, 8'h19);
        wr(8'hA0, 8'hF0);
        check("R4 err c1 no w3", {6'h0, rule_err}, 8'h02);
        rd_chk("R2 forced reserved", 1, 3'd0, 8'h19);
        check("R2 c1 phase1", {6'h0, phase[3:2]}, 8'h01);
    endtask

    task automatic t_restart_c1;
        wr(8'hA1, 8'h70);
        check("R5 c1 phase2", {6'h0, phase[3:2]}, 8'h02);
        wr(8'hA0, 8'h1D);
        check("R5 restart phase1", {6'h0, phase[3:2]}, 8'h01);
        rd_chk("R5 word1 kept", 1, 3'd1, 8'h70);
        wr(8'hA1, 8'h71);
        wr(8'hA1, 8'h02);
        wr(8'hA1, 8'h01);
        check("R5 c1 done", {7'h0, init_done[1]}, 8'h01);
        rd_chk("R5 word1 new", 1, 3'd1, 8'h71);
        rd_chk("R9 c0 word1 kept", 0, 3'd1, 8'h08);
    endtask

    task automatic t_runtime_c0;
        wr(8'h20, 8'h60);
        rd_chk("R6 cmd a", 0, 3'd5, 8'h60);
        wr(8'h20, 8'h0A);
        rd_chk("R6 cmd b", 0, 3'd6, 8'h0A);
        rd_chk("R6 cmd a kept", 0, 3'd5, 8'h60);
        check("R6 phase kept", {6'h0, phase[1:0]}, 8'h00);
        wr(8'h21, 8'hFB);
        rd_chk("R7 mask", 0, 3'd4, 8'hFB);
        check("R7 still done", {6'h0, init_done}, 8'h03);
        rd_chk("R9 c1 mask", 1, 3'd4, 8'h00);
    endtask

    task automatic t_ignored_mid_seq;
        wr(8'h20, 8'h11);
        check("R8 restart clears done", {7'h0, init_done[0]}, 8'h00);
        wr(8'h20, 8'h20);
        rd_chk("R8 cmd ignored", 0, 3'd5, 8'h60);
        check("R8 phase held", {6'h0, phase[1:0]}, 8'h01);
        repeat (3) @(negedge clk);
        check("R8 idle hold", {6'h0, phase[1:0]}, 8'h01);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset;
        t_ignored_before_init;
        t_full_init_c0;
        t_rule_err;
        t_restart_c1;
        t_runtime_c0;
        t_ignored_mid_seq;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule